// File: doc/BRIEF.md
# Multi-channel memory access arbiter

This block lets several independent request channels, plus an optional register-bus requester, share a single memory-controller style back end. Each channel writes read or write commands into its own command queue through a valid/ready stream. Results of that channel's reads come back through a second queue, also a valid/ready stream. A round-robin arbiter picks one ready requester at a time and drives its command onto the back-end port. It then holds that grant until the transaction finishes. Only one back-end transaction is in flight at any moment.

Back-pressure works as follows. A channel command moves on a clock edge where `ch_req_valid` and `ch_req_ready` are both high. A read result leaves the channel on an edge where `ch_rd_valid` and `ch_rd_ready` are both high. While a channel holds back its `ch_rd_ready`, its read queue fills, and the arbiter then stops granting that channel's reads. Its writes and the other requesters keep going.

An optional watchdog guards channel reads. If the back end does not acknowledge in time, the read completes with an error flag in place of data. Any acknowledge that shows up afterwards, while nothing is outstanding, is thrown away.

Top module: `mchan_mem_arb`

## Requirements
- R1: `ch_req_ready[i]` is high exactly when channel i's command queue holds fewer than `DEPTH` entries. A command is taken on an edge where valid and ready are both high. Its fields are `ch_req_wr` (1 = write, 0 = read), the address and the write data.
- R2: Requesters are numbered 0..`NCH`-1 for the channels and `NCH` for the bus port. The search for the next grant starts one past the last granted index, and after reset it starts at index 0. A channel is eligible when its command queue is non-empty. The bus port is eligible while `bus_req` is high. After a transaction completes, the port stays idle for one cycle before the next grant.
- R3: `mem_req` rises in the cycle after a grant. It then stays high, with `mem_wr`, `mem_addr` and `mem_wdata` held stable, until the cycle in which `mem_ack` is seen or the timeout fires.
- R4: Each channel read completed by `mem_ack` places `mem_rdata` with `ch_rd_err`=0 into that channel's read queue. Results come out in order on `ch_rd_valid`/`ch_rd_data`.
- R5: A channel read is granted only while that channel's read queue has fewer than `DEPTH` entries. A read blocked this way does not stop the writes of other channels or the bus port.
- R6: With `TMO_EN`=1, a channel read whose `mem_req` has been high for `TMO_CYC` cycles with no `mem_ack` completes with `ch_rd_err`=1 and data 0, and `mem_req` falls. An acknowledge in the last of those cycles still counts as a normal completion. Writes and bus transactions never time out.
- R7: A `mem_ack` while `mem_req` is low has no effect: no entry is added to any read queue.
- R8: `ch_cmd_pend[i]` is high while channel i's command queue is non-empty. `ch_rd_pend[i]` is high while its read queue holds an entry.
- R9: The bus requester holds `bus_req` and its fields stable until `bus_ack`, and drops `bus_req` in the following cycle. `bus_ack` is high exactly in the cycle where `mem_ack` completes a bus transaction, and `bus_rdata` carries `mem_rdata` in that cycle.
- R10: During and right after reset, `mem_req`, `bus_ack`, `ch_rd_valid`, `ch_cmd_pend` and `ch_rd_pend` are low, and every `ch_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req_valid | input | NCH | Per-channel command valid |
| ch_req_ready | output | NCH | Per-channel command queue has room |
| ch_req_wr | input | NCH | Per-channel command kind, 1 = write |
| ch_req_addr | input | NCH*ADDR_W | Per-channel command address |
| ch_req_wdata | input | NCH*DATA_W | Per-channel write data |
| ch_rd_valid | output | NCH | Per-channel read result available |
| ch_rd_ready | input | NCH | Per-channel read result accepted |
| ch_rd_data | output | NCH*DATA_W | Per-channel read result data |
| ch_rd_err | output | NCH | Per-channel read result timed out |
| ch_cmd_pend | output | NCH | Command queue non-empty |
| ch_rd_pend | output | NCH | Read result waiting |
| bus_req | input | 1 | Bus requester wants a transaction |
| bus_wr | input | 1 | Bus transaction kind, 1 = write |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_ack | output | 1 | Bus transaction completed |
| bus_rdata | output | DATA_W | Bus read data, valid with bus_ack |
| mem_req | output | 1 | Back-end transaction request |
| mem_wr | output | 1 | Back-end transaction kind |
| mem_addr | output | ADDR_W | Back-end address |
| mem_wdata | output | DATA_W | Back-end write data |
| mem_ack | input | 1 | Back-end acknowledge |
| mem_rdata | input | DATA_W | Back-end read data |

## Verification
The bench fills a command queue while the back end is slow, so that `ch_req_ready` must fall at exactly `DEPTH` entries. A design that counts one entry off would either drop a command or stall too early. It then stalls one channel's read consumer until its read queue is full. If the design ignored room in that queue, it would overwrite results or grant a read it cannot store. If it blocked the whole arbiter, the other channel's writes would stop. A silent back end is used to trip the timeout; the bench checks that the error entry appears after exactly `TMO_CYC` request cycles, and then sends a stray acknowledge while idle, which a faulty design would turn into a phantom read result. Round-robin order with all three requesters contending, a bus read held far past the timeout window, and a long mixed run with read-after-write addresses are each compared against the reference model on every cycle.

// File: rtl/mca_pkg.sv
package mca_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic {ARB_IDLE, ARB_BUSY} arb_st_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mca_fifo.sv
module mca_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PW = mca_pkg::idx_w(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step_ptr(wp);
      if (pop)  rp <= step_ptr(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  assign dout  = store[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  // R1: the queue never takes an entry while full, never gives one while empty
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/mca_rr.sv
module mca_rr #(
  parameter int N = 3
) (
  input  logic [N-1:0]                  elig,
  input  logic [mca_pkg::idx_w(N)-1:0] last,
  output logic [mca_pkg::idx_w(N)-1:0] pick,
  output logic                          any
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int IW = mca_pkg::idx_w(N);

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = int'(last) + k;
      if (j >= N) j = j - N;
      if (!any && elig[j]) begin
        any  = 1'b1;
        pick = IW'(j);
      end
    end
  end
endmodule

// File: rtl/mca_tmo.sv
module mca_tmo #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic ack,
  output logic expire
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (start)                  cnt <= '0;
    else if (run && !ack && !expire) cnt <= cnt + 1'b1;
  end

  assign expire = run && !ack && (cnt == CW'(CYC - 1));

  // R6: the wait count never passes the window
  a_r6_window: assert property (@(posedge clk) disable iff (!rst_n) run |-> (cnt < CW'(CYC)));
endmodule

// File: rtl/mchan_mem_arb.sv
module mchan_mem_arb #(
  parameter int NCH     = 2,
  parameter int BUS_EN  = 1,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 4,
  parameter int TMO_EN  = 1,
  parameter int TMO_CYC = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        ch_req_valid,
  output logic [NCH-1:0]        ch_req_ready,
  input  logic [NCH-1:0]        ch_req_wr,
  input  logic [NCH*ADDR_W-1:0] ch_req_addr,
  input  logic [NCH*DATA_W-1:0] ch_req_wdata,
  output logic [NCH-1:0]        ch_rd_valid,
  input  logic [NCH-1:0]        ch_rd_ready,
  output logic [NCH*DATA_W-1:0] ch_rd_data,
  output logic [NCH-1:0]        ch_rd_err,
  output logic [NCH-1:0]        ch_cmd_pend,
  output logic [NCH-1:0]        ch_rd_pend,
  input  logic                  bus_req,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic                  bus_ack,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  mem_req,
  output logic                  mem_wr,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic                  mem_ack,
  input  logic [DATA_W-1:0]     mem_rdata
);
  timeunit 1ns;
  timeprecision 1ps;
  import mca_pkg::*;

  localparam int NRQ   = NCH + ((BUS_EN != 0) ? 1 : 0);
  localparam int SW    = idx_w(NRQ);
  localparam int CMD_W = 1 + ADDR_W + DATA_W;
  localparam int RD_W  = DATA_W + 1;

  arb_st_e       st;
  logic [SW-1:0] sel, last, pick;
  logic          any, busy, is_ch, expire, done;
  logic          cur_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  logic [NRQ-1:0]   elig;
  logic [NCH-1:0]   acc_empty, acc_full, acc_pop, rd_empty, rd_full, rd_push;
  logic [CMD_W-1:0] acc_head [NCH];
  logic [RD_W-1:0]  rd_out   [NCH];
  logic [RD_W-1:0]  rd_din;

  assign busy = (st == ARB_BUSY);
  assign done = busy && (mem_ack || expire);

  // per-channel queue pair
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    mca_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (ch_req_valid[i] && !acc_full[i]),
      .din   ({ch_req_wr[i], ch_req_addr[i*ADDR_W +: ADDR_W], ch_req_wdata[i*DATA_W +: DATA_W]}),
      .pop   (acc_pop[i]),
      .dout  (acc_head[i]),
      .empty (acc_empty[i]),
      .full  (acc_full[i])
    );

    mca_fifo #(.W(RD_W), .DEPTH(DEPTH)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rd_push[i]),
      .din   (rd_din),
      .pop   (ch_rd_valid[i] && ch_rd_ready[i]),
      .dout  (rd_out[i]),
      .empty (rd_empty[i]),
      .full  (rd_full[i])
    );

    assign acc_pop[i]                   = done && is_ch && (sel == SW'(i));
    assign rd_push[i]                   = acc_pop[i] && !cur_wr;
    assign ch_req_ready[i]              = !acc_full[i];
    assign ch_rd_valid[i]               = !rd_empty[i];
    assign ch_rd_err[i]                 = rd_out[i][DATA_W];
    assign ch_rd_data[i*DATA_W +: DATA_W] = rd_out[i][DATA_W-1:0];
    assign ch_cmd_pend[i]               = !acc_empty[i];
    assign ch_rd_pend[i]                = !rd_empty[i];
    assign elig[i] = !acc_empty[i] && (acc_head[i][CMD_W-1] || !rd_full[i]);

    // R5: a channel read starts only with room for its result
    a_r5_room: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_req) && is_ch && (sel == SW'(i)) && !mem_wr) |-> !rd_full[i]);
  end

  if (BUS_EN != 0) begin : g_bus
    assign elig[NCH] = bus_req;
  end

  mca_rr #(.N(NRQ)) u_rr (
    .elig (elig),
    .last (last),
    .pick (pick),
    .any  (any)
  );

  // steer the granted command to the back end
  always_comb begin
    is_ch     = 1'b0;
    cur_wr    = bus_wr;
    cur_addr  = bus_addr;
    cur_wdata = bus_wdata;
    for (int i = 0; i < NCH; i++) begin
      if (sel == SW'(i)) begin
        is_ch = 1'b1;
        {cur_wr, cur_addr, cur_wdata} = acc_head[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ARB_IDLE;
      sel  <= '0;
      last <= SW'(NRQ - 1);
    end else begin
      case (st)
        ARB_IDLE: if (any) begin
          st   <= ARB_BUSY;
          sel  <= pick;
          last <= pick;
        end
        ARB_BUSY: if (done) st <= ARB_IDLE;
        default:  st <= ARB_IDLE;
      endcase
    end
  end

  if (TMO_EN != 0) begin : g_tmo
    mca_tmo #(.CYC(TMO_CYC)) u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (!busy && any),
      .run    (busy && is_ch && !cur_wr),
      .ack    (mem_ack),
      .expire (expire)
    );
  end else begin : g_no_tmo
    assign expire = 1'b0;
  end

  assign rd_din    = expire ? {1'b1, {DATA_W{1'b0}}} : {1'b0, mem_rdata};
  assign mem_req   = busy;
  assign mem_wr    = cur_wr;
  assign mem_addr  = cur_addr;
  assign mem_wdata = cur_wdata;
  assign bus_ack   = (BUS_EN != 0) && busy && !is_ch && mem_ack;
  assign bus_rdata = mem_rdata;

  // R3: an unfinished request keeps its command steady
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !expire) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_wr) && $stable(mem_wdata)));
  // R6: a timeout ends the request
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n) expire |=> !mem_req);
  // R2: at most one channel completes per cycle
  a_r2_single: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(acc_pop));
  // R9: the bus port is acknowledged only while its request is on the back end
  a_r9_bus_ack: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> (mem_req && mem_ack && (acc_pop == '0)));
endmodule

// File: tb/mchan_mem_arb_test.sv
module mchan_mem_arb_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NCH = 2;
  localparam int DEP = 4;
  localparam int TMO = 8;
  localparam int BUSI = 2;

  typedef struct { bit wr; bit [7:0] a; bit [15:0] d; } cmd_t;
  typedef struct { bit [15:0] d; bit e; } res_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]    ch_req_valid = '0, ch_req_wr = '0, ch_rd_ready = '0;
  logic [NCH*8-1:0]  ch_req_addr = '0;
  logic [NCH*16-1:0] ch_req_wdata = '0;
  logic [NCH-1:0]    ch_req_ready, ch_rd_valid, ch_rd_err, ch_cmd_pend, ch_rd_pend;
  logic [NCH*16-1:0] ch_rd_data;
  logic bus_req = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic bus_ack;
  logic [15:0] bus_rdata;
  logic mem_req, mem_wr, mem_ack = 1'b0;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0;

  always #4 clk = ~clk;

  mchan_mem_arb #(.NCH(NCH), .BUS_EN(1), .ADDR_W(8), .DATA_W(16),
                  .DEPTH(DEP), .TMO_EN(1), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n),
    .ch_req_valid(ch_req_valid), .ch_req_ready(ch_req_ready), .ch_req_wr(ch_req_wr),
    .ch_req_addr(ch_req_addr), .ch_req_wdata(ch_req_wdata),
    .ch_rd_valid(ch_rd_valid), .ch_rd_ready(ch_rd_ready), .ch_rd_data(ch_rd_data),
    .ch_rd_err(ch_rd_err), .ch_cmd_pend(ch_cmd_pend), .ch_rd_pend(ch_rd_pend),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  cmd_t src [NCH][$];
  cmd_t acc [NCH][$];
  res_t rdq [NCH][$];
  bit [15:0] bmem [256];
  bit   bus_pend = 1'b0;
  cmd_t bus_cmd;
  bit   m_busy = 1'b0;
  int   m_sel = 0, m_last = BUSI, m_cnt = 0, bk_wait = 0;
  bit   mute = 1'b0, force_ack = 1'b0;
  int   lat = 1;
  bit   rrdy [NCH];
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int rnd(input int n);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % n);
  endfunction

  // one clock of stimulus, comparison and model update; entered just after a falling edge
  task automatic step();
    cmd_t cur;
    bit ack, tmo, done;
    bit acc_ok [NCH];
    bit rd_pop [NCH];
    int g;
    for (int i = 0; i < NCH; i++) begin
      ch_req_valid[i] = src[i].size() > 0;
      if (src[i].size() > 0) begin
        ch_req_wr[i] = src[i][0].wr;
        ch_req_addr[i*8 +: 8] = src[i][0].a;
        ch_req_wdata[i*16 +: 16] = src[i][0].d;
      end
      ch_rd_ready[i] = rrdy[i];
    end
    bus_req = bus_pend;
    bus_wr = bus_cmd.wr;
    bus_addr = bus_cmd.a;
    bus_wdata = bus_cmd.d;
    cur = bus_cmd;
    if (m_busy && m_sel < NCH) cur = acc[m_sel][0];
    ack = force_ack || (m_busy && !mute && bk_wait >= lat);
    mem_ack = ack;
    mem_rdata = m_busy ? bmem[cur.a] : 16'h5A5A;
    #1;
    for (int i = 0; i < NCH; i++) begin
      chk("R1 ch_req_ready", ch_req_ready[i], acc[i].size() < DEP);
      chk("R8 ch_cmd_pend", ch_cmd_pend[i], acc[i].size() > 0);
      chk("R8 ch_rd_pend", ch_rd_pend[i], rdq[i].size() > 0);
      chk("R4 ch_rd_valid", ch_rd_valid[i], rdq[i].size() > 0);
      if (rdq[i].size() > 0) begin
        chk("R4 ch_rd_data", ch_rd_data[i*16 +: 16], rdq[i][0].d);
        chk("R6 ch_rd_err", ch_rd_err[i], rdq[i][0].e);
      end
    end
    chk("R3 mem_req", mem_req, m_busy);
    if (m_busy) begin
      chk("R2 mem_wr", mem_wr, cur.wr);
      chk("R2 mem_addr", mem_addr, cur.a);
      if (cur.wr) chk("R2 mem_wdata", mem_wdata, cur.d);
    end
    chk("R9 bus_ack", bus_ack, m_busy && m_sel == BUSI && ack);
    if (m_busy && m_sel == BUSI && ack && !cur.wr) chk("R9 bus_rdata", bus_rdata, bmem[cur.a]);

    tmo = m_busy && m_sel < NCH && !cur.wr && m_cnt == TMO - 1 && !ack;
    done = m_busy && (ack || tmo);
    g = -1;
    if (!m_busy) begin
      for (int k = 1; k <= NCH + 1; k++) begin
        int j;
        bit e;
        j = (m_last + k) % (NCH + 1);
        if (j < NCH) e = acc[j].size() > 0 && (acc[j][0].wr || rdq[j].size() < DEP);
        else e = bus_pend;
        if (e && g < 0) g = j;
      end
    end
    for (int i = 0; i < NCH; i++) begin
      acc_ok[i] = src[i].size() > 0 && acc[i].size() < DEP;
      rd_pop[i] = rrdy[i] && rdq[i].size() > 0;
    end
    if (done) begin
      res_t r;
      if (cur.wr && ack) bmem[cur.a] = cur.d;
      if (m_sel < NCH) begin
        if (!cur.wr) begin
          r.d = ack ? bmem[cur.a] : 16'h0;
          r.e = !ack;
          rdq[m_sel].push_back(r);
        end
        void'(acc[m_sel].pop_front());
      end else begin
        bus_pend = 1'b0;
      end
      m_busy = 1'b0;
      bk_wait = 0;
    end else if (m_busy) begin
      m_cnt++;
      bk_wait++;
    end else if (g >= 0) begin
      m_busy = 1'b1;
      m_sel = g;
      m_last = g;
      m_cnt = 0;
      bk_wait = 0;
    end
    for (int i = 0; i < NCH; i++) begin
      if (rd_pop[i]) void'(rdq[i].pop_front());
      if (acc_ok[i]) begin
        acc[i].push_back(src[i][0]);
        void'(src[i].pop_front());
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    repeat (n) step();
  endtask

  task automatic put(input int ch, input bit wr, input bit [7:0] a, input bit [15:0] d);
    cmd_t c;
    c.wr = wr; c.a = a; c.d = d;
    src[ch].push_back(c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog act=running exp=finished");
    finish_up();
  end

  initial begin
    for (int a = 0; a < 256; a++) bmem[a] = 16'(a * 3 + 16'h100);
    rrdy[0] = 1'b1;
    rrdy[1] = 1'b1;
    bus_cmd.wr = 1'b0; bus_cmd.a = '0; bus_cmd.d = '0;
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state
    chk("R10 mem_req", mem_req, 0);
    chk("R10 bus_ack", bus_ack, 0);
    chk("R10 ch_rd_valid", ch_rd_valid, 0);
    chk("R10 ch_cmd_pend", ch_cmd_pend, 0);
    chk("R10 ch_rd_pend", ch_rd_pend, 0);
    chk("R10 ch_req_ready", ch_req_ready, 2'b11);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: write then read back on one channel
    lat = 2;
    put(0, 1, 8'h10, 16'hBEEF);
    put(0, 0, 8'h10, 16'h0);
    put(0, 0, 8'h11, 16'h0);
    run(30);

    // R2: three requesters contend
    lat = 1;
    for (int k = 0; k < 3; k++) begin
      put(0, 1, 8'(8'h20 + k), 16'(16'hA000 + k));
      put(1, 0, 8'(8'h20 + k), 16'h0);
    end
    bus_cmd.wr = 1'b0; bus_cmd.a = 8'h21; bus_pend = 1'b1;
    run(60);

    // R1: slow back end lets the command queue fill
    lat = 6;
    for (int k = 0; k < 8; k++) put(0, 1, 8'(8'h30 + k), 16'(16'hC000 + k));
    run(110);

    // R5: read queue full blocks reads of channel 1 only
    lat = 1;
    rrdy[1] = 1'b0;
    for (int k = 0; k < 6; k++) put(1, 0, 8'(8'h30 + k), 16'h0);
    put(0, 1, 8'h40, 16'h1111);
    put(0, 1, 8'h41, 16'h2222);
    run(80);
    rrdy[1] = 1'b1;
    run(60);

    // R6: silent back end, then R7: stray acknowledge while idle
    rrdy[0] = 1'b0;
    mute = 1'b1;
    put(0, 0, 8'h05, 16'h0);
    run(16);
    force_ack = 1'b1;
    step();
    force_ack = 1'b0;
    run(3);
    rrdy[0] = 1'b1;
    run(4);

    // R9: bus read and channel write outlast the timeout window
    bus_cmd.wr = 1'b0; bus_cmd.a = 8'h41; bus_pend = 1'b1;
    put(1, 1, 8'h50, 16'h5555);
    run(14);
    mute = 1'b0;
    run(10);
    bus_cmd.wr = 1'b1; bus_cmd.a = 8'h60; bus_cmd.d = 16'h6060; bus_pend = 1'b1;
    run(6);
    put(0, 0, 8'h60, 16'h0);
    run(8);

    // mixed traffic, all requirements compared every cycle
    lat = 0;
    for (int c = 0; c < 600; c++) begin
      for (int i = 0; i < NCH; i++) begin
        if (src[i].size() < 3 && rnd(3) == 0)
          put(i, rnd(2) == 1, 8'(rnd(12)), 16'(rnd(65536)));
        rrdy[i] = rnd(4) != 0;
      end
      if (!bus_pend && rnd(8) == 0) begin
        bus_cmd.wr = rnd(2) == 1;
        bus_cmd.a = 8'(rnd(12));
        bus_cmd.d = 16'(rnd(65536));
        bus_pend = 1'b1;
      end
      if (c % 150 == 0) lat = rnd(3);
      step();
    end
    rrdy[0] = 1'b1;
    rrdy[1] = 1'b1;
    run(80);
    finish_up();
  end
endmodule